// File: doc/BRIEF.md
# Bidirectional Storage-Stage Bus Transceiver

The block connects two 18-bit ports, A and B, through two independent paths. One path runs from A to B and the other from B to A. Each path has a storage stage followed by an output driver. A latch-enable input and a path clock choose the stage mode. When latch-enable is high the stage is transparent. When latch-enable is low the stage captures on a high-to-low transition of the path clock, and it holds its value when the path clock stays steady. All bits of a port share the same controls. The A-to-B driver is enabled by a high level and the B-to-A driver by a low level.

The block is synthesizable and has no bidirectional pins. Each port is split into an external level and an external-driver flag on the input side. On the output side it has the resolved port level and a flag that shows the block is driving the port. A hold register per port stores the last resolved level. When neither the block nor an external agent drives a port, the port keeps that level. The path clocks and latch-enables are ordinary signals sampled on the system clock `clk_i`, so a falling path-clock edge is seen at the first system edge where the path clock reads low after it read high on the edge before. The block never resolves a state where both directions are enabled. It raises a conflict flag instead.

Top module: `bus_xcvr`

## Requirements
- R1: With the latch-enable of a path high, the stage is transparent: the driven port shows the source port level in the same cycle.
- R2: With latch-enable low, the stored value does not change across a system edge unless the path clock went from high (previous edge) to low (this edge); a low-to-high path-clock change stores nothing.
- R3: With latch-enable low, a high-to-low path-clock transition captures the source level present at that system edge, and the driven port shows it from the next cycle on.
- R4: The A-to-B driver is enabled by `ab_oe_i` = 1. With `ab_oe_i` = 0 the block does not drive B (`b_drv_o` = 0).
- R5: The B-to-A path has its own latch-enable and clock with the rules of R1 to R3. Its driver is enabled by `ba_oe_ni` = 0, and with `ba_oe_ni` = 1 the block does not drive A.
- R6: When a port is driven neither by the block nor externally, its level stays at the last resolved level (bus hold).
- R7: When the block does not drive a port and the external-driver flag is 1, the port level equals the external level.
- R8: `conflict_o` is 1 exactly when both directions are enabled at once. Both drivers stay on, and each port shows the block's own drive.
- R9: Reset (`rst_ni` = 0) clears both stored values and both hold registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ab_le_i | input | 1 | A-to-B latch-enable (high = transparent) |
| ab_clk_i | input | 1 | A-to-B path clock, captures on falling edge |
| ab_oe_i | input | 1 | A-to-B output enable, active high |
| ba_le_i | input | 1 | B-to-A latch-enable (high = transparent) |
| ba_clk_i | input | 1 | B-to-A path clock, captures on falling edge |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| a_ext_i | input | 18 | Level put on port A by an external agent |
| a_ext_en_i | input | 1 | External agent drives port A |
| b_ext_i | input | 18 | Level put on port B by an external agent |
| b_ext_en_i | input | 1 | External agent drives port B |
| a_pad_o | output | 18 | Resolved level of port A |
| a_drv_o | output | 1 | Block drives port A |
| b_pad_o | output | 18 | Resolved level of port B |
| b_drv_o | output | 1 | Block drives port B |
| conflict_o | output | 1 | Both directions enabled |

## Verification
Each path is driven through transparent phases with two different alternating data words, so a missing or stale pass-through shows up. A rising path-clock edge and several idle cycles are then applied with changing source data, which tells holding apart from capturing. A single falling edge follows, and the output must change exactly one cycle after the capturing system edge. The port-side patterns cover a port that is released with no driver, one that is released to an external driver, and one where both directions are enabled. These separate bus hold from external resolution and from the conflict case.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    ST_PASS    = 2'd0,
    ST_HOLD    = 2'd1,
    ST_CAPTURE = 2'd2
  } store_mode_e;

  function automatic store_mode_e mode_of(input logic le, input logic fall);
    if (le)        return ST_PASS;
    else if (fall) return ST_CAPTURE;
    else           return ST_HOLD;
  endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign fall_o = lvl_q & ~lvl_i;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic         pclk_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  logic         fall;
  logic [W-1:0] data_q;
  store_mode_e  mode;

  xcvr_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pclk_i),
    .fall_o(fall)
  );

  assign mode = mode_of(le_i, fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else begin
      unique case (mode)
        ST_PASS, ST_CAPTURE: data_q <= din_i;
        default:             data_q <= data_q;
      endcase
    end
  end

  // transparent mode bypasses the register
  assign dout_o = (mode == ST_PASS) ? din_i : data_q;
endmodule

// File: rtl/xcvr_port.sv
module xcvr_port #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         drv_en_i,
  input  logic [W-1:0] drv_val_i,
  input  logic         ext_en_i,
  input  logic [W-1:0] ext_val_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] src_o
);
  logic [W-1:0] hold_q;

  // level seen by the opposite path: excludes own drive to avoid a loop
  assign src_o = ext_en_i ? ext_val_i : hold_q;
  assign pad_o = drv_en_i ? drv_val_i : src_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= pad_o;
  end
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int W          = 18,
  parameter bit AB_OE_HIGH = 1'b1,
  parameter bit BA_OE_HIGH = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ab_le_i,
  input  logic         ab_clk_i,
  input  logic         ab_oe_i,
  input  logic         ba_le_i,
  input  logic         ba_clk_i,
  input  logic         ba_oe_ni,
  input  logic [W-1:0] a_ext_i,
  input  logic         a_ext_en_i,
  input  logic [W-1:0] b_ext_i,
  input  logic         b_ext_en_i,
  output logic [W-1:0] a_pad_o,
  output logic         a_drv_o,
  output logic [W-1:0] b_pad_o,
  output logic         b_drv_o,
  output logic         conflict_o
);
  localparam int NDIR = 2;
  localparam bit [NDIR-1:0] OE_HIGH = {BA_OE_HIGH, AB_OE_HIGH};

  // index 0: A to B, index 1: B to A
  logic [NDIR-1:0]        le, pclk, oe_raw, en;
  logic [NDIR-1:0][W-1:0] src, dout;
  // port index 0: A, 1: B
  logic [NDIR-1:0]        ext_en;
  logic [NDIR-1:0][W-1:0] ext_val, pad, psrc;

  assign le      = {ba_le_i, ab_le_i};
  assign pclk    = {ba_clk_i, ab_clk_i};
  assign oe_raw  = {ba_oe_ni, ab_oe_i};
  assign ext_en  = {b_ext_en_i, a_ext_en_i};
  assign ext_val = {b_ext_i, a_ext_i};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    if (OE_HIGH[d]) begin : g_hi
      assign en[d] = oe_raw[d];
    end else begin : g_lo
      assign en[d] = ~oe_raw[d];
    end

    // path d reads port d and drives port 1-d
    assign src[d] = psrc[d];

    xcvr_store #(.W(W)) u_store (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .le_i  (le[d]),
      .pclk_i(pclk[d]),
      .din_i (src[d]),
      .dout_o(dout[d])
    );

    xcvr_port #(.W(W)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .drv_en_i (en[NDIR-1-d]),
      .drv_val_i(dout[NDIR-1-d]),
      .ext_en_i (ext_en[d]),
      .ext_val_i(ext_val[d]),
      .pad_o    (pad[d]),
      .src_o    (psrc[d])
    );
  end

  assign a_pad_o    = pad[0];
  assign b_pad_o    = pad[1];
  assign a_drv_o    = en[1];
  assign b_drv_o    = en[0];
  assign conflict_o = &en;
endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ab_le_i,
  input logic         ab_clk_i,
  input logic         ab_oe_i,
  input logic         ba_oe_ni,
  input logic [W-1:0] a_ext_i,
  input logic         a_ext_en_i,
  input logic [W-1:0] b_ext_i,
  input logic         b_ext_en_i,
  input logic [W-1:0] a_pad_o,
  input logic         a_drv_o,
  input logic [W-1:0] b_pad_o,
  input logic         b_drv_o,
  input logic         conflict_o
);
  assert_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_le_i && ab_oe_i && ba_oe_ni && a_ext_en_i) |-> b_pad_o == a_ext_i);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_oe_i && !ab_le_i && !($past(ab_clk_i) && !ab_clk_i))
    |=> (!ab_oe_i || ab_le_i || $stable(b_pad_o)));

  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && $past(ab_clk_i) && !ab_clk_i && ba_oe_ni && a_ext_en_i)
    |=> (!ab_oe_i || ab_le_i || b_pad_o == $past(a_ext_i)));

  assert_bushold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!b_drv_o && !b_ext_en_i) |=> (b_drv_o || b_ext_en_i || $stable(b_pad_o)));

  assert_ext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_drv_o && a_ext_en_i) |-> a_pad_o == a_ext_i);

  assert_conflict_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> (a_drv_o && b_drv_o));
endmodule

bind bus_xcvr bus_xcvr_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ab_le_i   (ab_le_i),
  .ab_clk_i  (ab_clk_i),
  .ab_oe_i   (ab_oe_i),
  .ba_oe_ni  (ba_oe_ni),
  .a_ext_i   (a_ext_i),
  .a_ext_en_i(a_ext_en_i),
  .b_ext_i   (b_ext_i),
  .b_ext_en_i(b_ext_en_i),
  .a_pad_o   (a_pad_o),
  .a_drv_o   (a_drv_o),
  .b_pad_o   (b_pad_o),
  .b_drv_o   (b_drv_o),
  .conflict_o(conflict_o)
);

// File: tb/sim_bus_xcvr.sv
`timescale 1ns/1ps
module sim_bus_xcvr;
  localparam int W = 18;

  typedef struct {
    string        req;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         adrv;
    logic         bdrv;
    logic         conf;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ab_le = 0, ab_clk = 0, ab_oe = 0;
  logic         ba_le = 0, ba_clk = 0, ba_oe_n = 1;
  logic [W-1:0] a_ext = '0, b_ext = '0;
  logic         a_ext_en = 0, b_ext_en = 0;
  logic [W-1:0] a_pad, b_pad;
  logic         a_drv, b_drv, conflict;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_xcvr #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ab_le_i(ab_le), .ab_clk_i(ab_clk), .ab_oe_i(ab_oe),
    .ba_le_i(ba_le), .ba_clk_i(ba_clk), .ba_oe_ni(ba_oe_n),
    .a_ext_i(a_ext), .a_ext_en_i(a_ext_en),
    .b_ext_i(b_ext), .b_ext_en_i(b_ext_en),
    .a_pad_o(a_pad), .a_drv_o(a_drv),
    .b_pad_o(b_pad), .b_drv_o(b_drv),
    .conflict_o(conflict)
  );

  task automatic expect_item(input string req, input logic [W-1:0] ea, input logic [W-1:0] eb,
                             input logic ead, input logic ebd, input logic ec);
    item_t it;
    it.req = req; it.a = ea; it.b = eb; it.adrv = ead; it.bdrv = ebd; it.conf = ec;
    q.push_back(it);
  endtask

  // monitor: compares one cycle's outputs after the driver settles them
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (a_pad !== it.a || b_pad !== it.b || a_drv !== it.adrv ||
            b_drv !== it.bdrv || conflict !== it.conf) begin
          n_fail++;
          $display("FAIL %s: a=%h b=%h adrv=%b bdrv=%b conf=%b, expected a=%h b=%h adrv=%b bdrv=%b conf=%b",
                   it.req, a_pad, b_pad, a_drv, b_drv, conflict,
                   it.a, it.b, it.adrv, it.bdrv, it.conf);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: stored value cleared, B driven with zero
    @(negedge clk); ab_oe = 1;
    expect_item("R9", 18'h00000, 18'h00000, 0, 1, 0);
    // R1: transparent A to B, two words
    @(negedge clk); a_ext_en = 1; a_ext = 18'h2A5A5; ab_le = 1;
    expect_item("R1", 18'h2A5A5, 18'h2A5A5, 0, 1, 0);
    @(negedge clk); a_ext = 18'h15A5A;
    expect_item("R1", 18'h15A5A, 18'h15A5A, 0, 1, 0);
    // R2: latch closed, data changes ignored
    @(negedge clk); ab_le = 0; a_ext = 18'h3FFFF;
    expect_item("R2", 18'h3FFFF, 18'h15A5A, 0, 1, 0);
    // R2: rising path clock stores nothing
    @(negedge clk); ab_clk = 1; a_ext = 18'h00F0F;
    expect_item("R2", 18'h00F0F, 18'h15A5A, 0, 1, 0);
    // R3: falling edge, visible after the next system edge
    @(negedge clk); ab_clk = 0; a_ext = 18'h12345;
    expect_item("R3", 18'h12345, 18'h15A5A, 0, 1, 0);
    @(negedge clk); a_ext = 18'h0BEEF;
    expect_item("R3", 18'h0BEEF, 18'h12345, 0, 1, 0);
    @(negedge clk);
    expect_item("R2", 18'h0BEEF, 18'h12345, 0, 1, 0);
    // R4 + R6: release B, nobody drives, level held
    @(negedge clk); ab_oe = 0;
    expect_item("R4", 18'h0BEEF, 18'h12345, 0, 0, 0);
    @(negedge clk);
    expect_item("R6", 18'h0BEEF, 18'h12345, 0, 0, 0);
    // R7: external agent on B
    @(negedge clk); b_ext_en = 1; b_ext = 18'h2AAAA;
    expect_item("R7", 18'h0BEEF, 18'h2AAAA, 0, 0, 0);
    // R5: B to A transparent, active-low enable
    @(negedge clk); a_ext_en = 0; ba_le = 1; ba_oe_n = 0;
    expect_item("R5", 18'h2AAAA, 18'h2AAAA, 1, 0, 0);
    @(negedge clk); ba_le = 0; b_ext = 18'h11111;
    expect_item("R5", 18'h2AAAA, 18'h11111, 1, 0, 0);
    @(negedge clk); ba_clk = 1;
    expect_item("R5", 18'h2AAAA, 18'h11111, 1, 0, 0);
    @(negedge clk); ba_clk = 0; b_ext = 18'h33333;
    expect_item("R5", 18'h2AAAA, 18'h33333, 1, 0, 0);
    @(negedge clk); b_ext = 18'h00001;
    expect_item("R5", 18'h33333, 18'h00001, 1, 0, 0);
    // R6: release A with no external driver
    @(negedge clk); ba_oe_n = 1;
    expect_item("R6", 18'h33333, 18'h00001, 0, 0, 0);
    // R8: both directions on
    @(negedge clk); ab_oe = 1; ba_oe_n = 0;
    expect_item("R8", 18'h33333, 18'h12345, 1, 1, 1);
    // R4/R5: both off again
    @(negedge clk); ab_oe = 0; ba_oe_n = 1;
    expect_item("R8", 18'h33333, 18'h00001, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule